// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt request pins, brings each one into the clock domain through a two-stage synchroniser, and classifies it according to a per-pin trigger code. The trigger can be a falling edge, a rising edge, a low level, a high level or either edge. A detected request sets a pending bit. A pin whose pending bit is set is forwarded only when two conditions hold: its mask bit is clear and its 4-bit priority field is nonzero. Forwarded pins are ORed onto one combined request line. When an individual-pin mode bit is set, they are also driven onto separate per-pin lines toward a parent controller.

Software reaches the block over a simple synchronous register bus. Writes are taken on the clock edge while the write strobe is high. Read data is combinational from the word address. The register word addresses are: 0 trigger codes, 1 priorities, 2 pending, 3 mask-set, 4 mask-clear and 5 control. In every register, pin 0 sits at the most significant end. The trigger and priority registers are always 32 bits. The pending, mask-set and mask-clear registers use a configurable width of 8 or 32 bits, and the bit for pin k lies at position width−1−k. Pending bits are cleared by writing zero to them. Masks are changed through two write-only registers, one that sets mask bits and one that clears them.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset all pins are masked, and the pending, trigger, priority and control registers read zero. `irqOut` and every `pinIrq` bit are 0.
- R2: A pin change that meets its trigger condition is visible in the pending register no later than the fourth clock edge after the change. The pin passes through two synchroniser stages and an edge is found against the previous synchronised value.
- R3: Trigger code 0 sets pending on a falling edge, 1 on a rising edge, 2 while the pin is low, 3 while the pin is high and 4 on either edge. Any other code never sets pending.
- R4: The trigger field of pin n occupies bits [32−n·W−1 : 32−(n+1)·W] of register 0, where W is the field width (4 by default, or 2). The 4-bit priority field of pin n occupies bits [31−4n : 28−4n] of register 1.
- R5: Reading register 2 returns the pending bit of pin k at position SRC_W−1−k. All other bits read zero.
- R6: Writing register 2 clears each pending bit whose position holds 0 and leaves each bit whose position holds 1 unchanged. A detection in the same cycle as the write takes precedence over the clear.
- R7: Writing 1 to a pin's position in register 3 masks that pin. Positions written 0 leave the mask unchanged. Registers 3 and 4 read as zero.
- R8: Writing 1 to a pin's position in register 4 unmasks that pin. Positions written 0 leave the mask unchanged.
- R9: A pin whose priority field is zero is never forwarded. Any nonzero priority lets it through.
- R10: `irqOut` is high exactly when at least one pin is pending, unmasked and has nonzero priority.
- R11: Register 5 stores only bit 23, the individual-pin mode bit. `pinIrq[k]` equals the forwarded state of pin k when this bit is 1 and is 0 when it is 0.
- R12: In the two level modes, pending is set again on every cycle the level is present, so a clear written while the level persists has no lasting effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Asynchronous request pins, bit k is pin k |
| busAddr | input | 3 | Register word address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| irqOut | output | 1 | Combined request |
| pinIrq | output | NUM_PINS | Per-pin forwarded request, bit k is pin k |

## Verification
Every pin is exercised with all sixteen trigger codes. Each code goes through the same four-phase pattern: a rise, a steady high after a clear, a fall, and a steady low after a clear. This pattern separates edge detection from level detection, shows which edge each code reacts to, and shows that level modes re-arm after a clear. It also confirms that out-of-range codes stay silent and that the pending bit appears at the mirrored position for that pin only. A sweep over all 256 unmask patterns follows. Each pattern is combined with a derived priority pattern, a partial re-mask and an alternating mode bit, which checks the three-way gating of the outputs against arithmetic. A fixed pending pattern written back as ones and zeros checks that ones hold and zeros clear.

// File: rtl/extpin_irq_pkg.sv
package extpin_irq_pkg;
  localparam int REG_W    = 32;
  localparam int PRIO_W   = 4;
  localparam int MODE_BIT = 23;

  typedef enum logic [2:0] {
    SEL_TRIG  = 3'd0,
    SEL_PRIO  = 3'd1,
    SEL_PEND  = 3'd2,
    SEL_MSET  = 3'd3,
    SEL_MCLR  = 3'd4,
    SEL_CTRL  = 3'd5,
    SEL_NONE6 = 3'd6,
    SEL_NONE7 = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrTrig;
    logic wrPrio;
    logic wrPend;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrCtrl;
  } strobes_t;
endpackage

// File: rtl/extpin_irq_decode.sv
module extpin_irq_decode
  import extpin_irq_pkg::*;
(
  input  logic [2:0] busAddr,
  input  logic       busWe,
  output regSel_e    readSel,
  output strobes_t   strobes
);
  always_comb begin
    readSel = regSel_e'(busAddr);
    strobes = '0;
    if (busWe) begin
      unique case (readSel)
        SEL_TRIG: strobes.wrTrig    = 1'b1;
        SEL_PRIO: strobes.wrPrio    = 1'b1;
        SEL_PEND: strobes.wrPend    = 1'b1;
        SEL_MSET: strobes.wrMaskSet = 1'b1;
        SEL_MCLR: strobes.wrMaskClr = 1'b1;
        SEL_CTRL: strobes.wrCtrl    = 1'b1;
        default:  strobes           = '0;
      endcase
    end
  end
endmodule

// File: rtl/extpin_irq_datapath.sv
module extpin_irq_datapath
  import extpin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int TRIG_W   = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  strobes_t            strobes,
  input  regSel_e             readSel,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] pinIrq
);
  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] hit, pending, masked, ready;
  logic [REG_W-1:0]    trigReg, prioReg;
  logic                modeBit;
  logic [REG_W-1:0]    pendView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigReg <= '0;
      prioReg <= '0;
      modeBit <= 1'b0;
    end else begin
      if (strobes.wrTrig) trigReg <= wdata;
      if (strobes.wrPrio) prioReg <= wdata;
      if (strobes.wrCtrl) modeBit <= wdata[MODE_BIT];
    end
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    localparam int TRIG_LSB = REG_W - (k + 1) * TRIG_W;
    localparam int PRIO_LSB = REG_W - (k + 1) * PRIO_W;
    localparam int BUS_BIT  = SRC_W - 1 - k;
    logic [3:0] code;
    logic       prioOn;

    assign code   = 4'(trigReg[TRIG_LSB +: TRIG_W]);
    assign prioOn = |prioReg[PRIO_LSB +: PRIO_W];

    always_comb begin
      unique case (code)
        4'd0:    hit[k] = prevB[k] & ~syncB[k];
        4'd1:    hit[k] = ~prevB[k] & syncB[k];
        4'd2:    hit[k] = ~syncB[k];
        4'd3:    hit[k] = syncB[k];
        4'd4:    hit[k] = prevB[k] ^ syncB[k];
        default: hit[k] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[k] <= 1'b0;
        masked[k]  <= 1'b1;
      end else begin
        pending[k] <= (strobes.wrPend ? (pending[k] & wdata[BUS_BIT]) : pending[k]) | hit[k];
        if (strobes.wrMaskSet && wdata[BUS_BIT])      masked[k] <= 1'b1;
        else if (strobes.wrMaskClr && wdata[BUS_BIT]) masked[k] <= 1'b0;
      end
    end

    assign ready[k]  = pending[k] & ~masked[k] & prioOn;
    assign pinIrq[k] = ready[k] & modeBit;

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wrMaskSet && wdata[BUS_BIT]) |=> masked[k]); // R7
    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wrMaskClr && wdata[BUS_BIT]) |=> !masked[k]); // R8
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.wrPend && !wdata[BUS_BIT] && !hit[k]) |=> !pending[k]); // R6
    AST_PRIO_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
      (prioReg[PRIO_LSB +: PRIO_W] == '0) |-> !pinIrq[k]); // R9
  end

  always_comb begin
    pendView = '0;
    for (int k = 0; k < NUM_PINS; k++) pendView[SRC_W-1-k] = pending[k];
  end

  always_comb begin
    unique case (readSel)
      SEL_TRIG: rdata = trigReg;
      SEL_PRIO: rdata = prioReg;
      SEL_PEND: rdata = pendView;
      SEL_CTRL: begin
        rdata = '0;
        rdata[MODE_BIT] = modeBit;
      end
      default:  rdata = '0;
    endcase
  end

  assign irqOut = |ready;

  AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pending != '0)); // R10
  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !modeBit |-> (pinIrq == '0)); // R11
endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl
  import extpin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int TRIG_W   = 4,
  parameter int SRC_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [2:0]          busAddr,
  input  logic                busWe,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] pinIrq
);
  regSel_e  readSel;
  strobes_t strobes;

  extpin_irq_decode u_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .readSel (readSel),
    .strobes (strobes)
  );

  extpin_irq_datapath #(
    .NUM_PINS (NUM_PINS),
    .TRIG_W   (TRIG_W),
    .SRC_W    (SRC_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobes (strobes),
    .readSel (readSel),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .irqOut  (irqOut),
    .pinIrq  (pinIrq)
  );
endmodule

// File: tb/extpin_irq_ctrl_tb.sv
module extpin_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic [NP-1:0] pinIrq;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extpin_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .pinIrq(pinIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [7:0] busToPin(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic run();
    logic [31:0] v;
    // R1 reset state
    rd(3'd0, v); check("R1 trig", v, 0);
    rd(3'd1, v); check("R1 prio", v, 0);
    rd(3'd2, v); check("R1 pend", v, 0);
    rd(3'd5, v); check("R1 ctrl", v, 0);
    rd(3'd3, v); check("R7 mset reads zero", v, 0);
    rd(3'd4, v); check("R7 mclr reads zero", v, 0);
    check("R1 irqOut", {31'd0, irqOut}, 0);
    check("R1 pinIrq", {24'd0, pinIrq}, 0);

    // R2 R3 R4 R5 R12: every pin, every code, four phases
    for (int k = 0; k < NP; k++) begin
      for (int code = 0; code < 16; code++) begin
        logic [7:0] bitv;
        logic [3:0] e;
        bitv = 8'h80 >> k;
        case (code)
          0: e = 4'b0010;   // phases s1..s4 as e[3]..e[0]
          1: e = 4'b1000;
          2: e = 4'b1011;
          3: e = 4'b1110;
          4: e = 4'b1010;
          default: e = 4'b0000;
        endcase
        wr(3'd0, 32'(code) << (28 - 4*k));
        wr(3'd2, 32'd0);
        idle(4);
        pinIn[k] = 1'b1; idle(4);
        rd(3'd2, v); check("R2 R3 R5 rise phase", v, e[3] ? {24'd0, bitv} : 0);
        wr(3'd2, 32'd0); idle(4);
        rd(3'd2, v); check("R3 R12 steady high", v, e[2] ? {24'd0, bitv} : 0);
        pinIn[k] = 1'b0; idle(4);
        rd(3'd2, v); check("R3 R4 fall phase", v, e[1] ? {24'd0, bitv} : 0);
        wr(3'd2, 32'd0); idle(4);
        rd(3'd2, v); check("R3 R12 steady low", v, e[0] ? {24'd0, bitv} : 0);
      end
    end
    wr(3'd0, 32'd0); wr(3'd2, 32'd0);
    rd(3'd0, v); check("R4 trig readback", v, 0);

    // R6: ones keep, zeros clear
    wr(3'd0, 32'h11111111);
    pinIn = '1; idle(5);
    rd(3'd2, v); check("R6 all pending", v, 32'hFF);
    wr(3'd2, 32'hA5); rd(3'd2, v); check("R6 partial clear", v, 32'hA5);
    wr(3'd2, 32'hFF); rd(3'd2, v); check("R6 ones keep", v, 32'hA5);
    wr(3'd2, 32'h00); rd(3'd2, v); check("R6 zeros clear", v, 0);

    // R11 control register
    wr(3'd5, 32'hFFFFFFFF); rd(3'd5, v); check("R11 ctrl only mode bit", v, 32'h00800000);

    // R7 R8 R9 R10 R11: gating sweep with all pins pending at high level
    wr(3'd0, 32'h33333333); idle(2);
    for (int m = 0; m < 256; m++) begin
      logic [7:0] q, s, rdy;
      logic [31:0] pr;
      logic mode;
      q = 8'((m * 37 + 5) & 8'hFF);
      s = 8'(m) & 8'h0F;
      mode = m[0];
      pr = '0;
      for (int k = 0; k < NP; k++)
        if (q[7-k]) pr[28-4*k +: 4] = 4'(1 + ((m + k) % 15));
      wr(3'd1, pr);
      wr(3'd5, mode ? 32'h00800000 : 32'h0);
      wr(3'd3, 32'hFF);
      wr(3'd4, 32'(m));
      rdy = 8'(m) & q;
      @(negedge clk); #1;
      check("R8 R9 R10 irqOut after unmask", {31'd0, irqOut}, {31'd0, |rdy});
      check("R11 pinIrq after unmask", {24'd0, pinIrq}, mode ? {24'd0, busToPin(rdy)} : 0);
      wr(3'd3, 32'(s));
      rdy = 8'(m) & ~s & q;
      @(negedge clk); #1;
      check("R7 R10 irqOut after partial mask", {31'd0, irqOut}, {31'd0, |rdy});
      check("R7 R9 pinIrq after partial mask", {24'd0, pinIrq}, mode ? {24'd0, busToPin(rdy)} : 0);
    end
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    fork
      begin : main_thread
        run();
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule